// File: doc/BRIEF.md
# Four-to-two compressor tree multiplier

This block multiplies two unsigned N-bit integers and returns the full 2N-bit product. Every multiplier bit gates a copy of the multiplicand, shifted to that bit's weight, giving N partial products. A balanced binary tree of 4-2 compressors reduces these partial products to a sum vector and a carry vector. Each compressor is two carry-save rows in series. A parallel-prefix adder then adds the two vectors, so the delay grows with the logarithm of the width.

When the partial-product count is not a power of two, the leaf count is rounded up and the spare leaves are tied to zero, which keeps every tree level full. All intermediate vectors are 2N bits wide. Carries out of the top bit are dropped, because the true product always fits. The caller raises a strobe with the operands. The product is captured into an output register, and a matching valid flag goes high one clock later. The width parameter N must be at least 4.

Top module: `cmp42_mult`

## Requirements
- R1: One clock edge after a cycle with `in_vld` high, `prod` equals the unsigned product `op_a * op_b` of that cycle's operands, as a 2N-bit value.
- R2: `out_vld` is high in exactly the cycle that follows a cycle with `in_vld` high, and is low after any cycle with `in_vld` low.
- R3: While `in_vld` is low, `prod` keeps its last value whatever `op_a` and `op_b` do.
- R4: While `rst_n` is low, `out_vld` is 0 and `prod` is all zeros.
- R5: With both operands all ones, `prod` equals 2^(2N) - 2^(N+1) + 1, so that no carry is lost inside the top 2N bits.
- R6: With either operand zero, `prod` is zero whatever the other operand holds.
- R7: With an operand equal to a single set bit 2^k, `prod` equals the other operand shifted left by k.
- R8: Strobes on consecutive cycles each give their own product on the following cycle, with no bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operands are valid this cycle |
| op_a | input | N | Multiplicand, unsigned |
| op_b | input | N | Multiplier, unsigned |
| out_vld | output | 1 | `prod` holds a new result |
| prod | output | 2N | Registered product |

## Verification
At N = 8, every pair of operands is streamed back to back. This covers every carry pattern through the compressor tree and the prefix adder, and it also shows that results do not leak between consecutive strobes. At N = 16, a directed set is applied: zero operands, which tell a gating fault in the partial products from a carry fault; all-ones operands, which drive the longest carry chain and test the dropped top carry; and single-bit operands, which expose a shift or leaf-ordering error. Random pairs follow, issued with idle gaps. During those gaps the operands change while the strobe is low, which separates holding the product from recomputing it. Samples taken during reset and just after it confirm the cleared state.

// File: rtl/mul42_pkg.sv
package mul42_pkg;

  // one-bit full adder viewed as a counter of ones: low bit
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  // one-bit full adder viewed as a counter of ones: high bit
  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/mul42_ppgen.sv
module mul42_ppgen #(
  parameter int N = 8,
  parameter int L = 8,
  localparam int W = 2 * N
) (
  input  logic [N-1:0] mcand,
  input  logic [N-1:0] mplier,
  output logic [W-1:0] pp [L]
);

  for (genvar i = 0; i < L; i++) begin : g_row
    if (i < N) begin : g_live
      // multiplicand gated by one multiplier bit, weighted by its position
      assign pp[i] = {{N{1'b0}}, mcand & {N{mplier[i]}}} << i;
    end else begin : g_pad
      assign pp[i] = '0;
    end
  end

endmodule

// File: rtl/mul42_csa.sv
module mul42_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  import mul42_pkg::*;

  logic [W-2:0] maj;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i] = fa_sum(x[i], y[i], z[i]);
    if (i < W - 1) begin : g_cy
      assign maj[i] = fa_carry(x[i], y[i], z[i]);
    end
  end

  // carries move up one weight; the top carry is beyond the product width
  assign c = {maj, 1'b0};

endmodule

// File: rtl/mul42_c42.sv
module mul42_c42 #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] e,
  output logic [W-1:0] f
);

  logic [W-1:0] mid_s;
  logic [W-1:0] mid_c;

  mul42_csa #(.W(W)) i_row0 (.x(a), .y(b), .z(c), .s(mid_s), .c(mid_c));
  mul42_csa #(.W(W)) i_row1 (.x(mid_s), .y(mid_c), .z(d), .s(e), .c(f));

endmodule

// File: rtl/mul42_tree.sv
module mul42_tree #(
  parameter int W = 16,
  parameter int L = 8,
  localparam int LVLS = $clog2(L) - 1
) (
  input  logic [W-1:0] pp [L],
  output logic [W-1:0] red_s,
  output logic [W-1:0] red_c
);

  for (genvar lv = 0; lv < LVLS; lv++) begin : g_lvl
    localparam int IN_CNT = L >> lv;
    logic [W-1:0] src [IN_CNT];
    logic [W-1:0] dst [IN_CNT/2];

    if (lv == 0) begin : g_first
      assign src = pp;
    end else begin : g_rest
      assign src = g_lvl[lv-1].dst;
    end

    for (genvar j = 0; j < IN_CNT / 4; j++) begin : g_node
      mul42_c42 #(.W(W)) i_node (
        .a(src[4*j]),   .b(src[4*j+1]),
        .c(src[4*j+2]), .d(src[4*j+3]),
        .e(dst[2*j]),   .f(dst[2*j+1])
      );
    end
  end

  assign red_s = g_lvl[LVLS-1].dst[0];
  assign red_c = g_lvl[LVLS-1].dst[1];

endmodule

// File: rtl/mul42_ks.sv
module mul42_ks #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);

  // parallel-prefix sum: log2(W) generate/propagate combining stages
  function automatic logic [W-1:0] ks_add(input logic [W-1:0] u, input logic [W-1:0] v);
    logic [W-1:0] g, p, gn, pn, half;
    g    = u & v;
    p    = u ^ v;
    half = p;
    for (int d = 1; d < W; d = d * 2) begin
      gn = g;
      pn = p;
      for (int i = d; i < W; i++) begin
        gn[i] = g[i] | (p[i] & g[i-d]);
        pn[i] = p[i] & p[i-d];
      end
      g = gn;
      p = pn;
    end
    return half ^ {g[W-2:0], 1'b0};
  endfunction

  assign sum = ks_add(x, y);

endmodule

// File: rtl/cmp42_mult.sv
module cmp42_mult #(
  parameter int N = 8,
  localparam int W = 2 * N,
  localparam int L = (N <= 4) ? 4 : (1 << $clog2(N))
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic         out_vld,
  output logic [W-1:0] prod
);

  logic [W-1:0] pp [L];
  logic [W-1:0] tree_sum;
  logic [W-1:0] tree_carry;
  logic [W-1:0] fast_sum;

  mul42_ppgen #(.N(N), .L(L)) i_ppgen (.mcand(op_a), .mplier(op_b), .pp(pp));

  mul42_tree #(.W(W), .L(L)) i_tree (.pp(pp), .red_s(tree_sum), .red_c(tree_carry));

  mul42_ks #(.W(W)) i_cpa (.x(tree_sum), .y(tree_carry), .sum(fast_sum));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      prod    <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) prod <= fast_sum;
    end
  end

  // R1
  carry_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tree_carry[0] == 1'b0);

  // R1
  tree_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> (tree_sum + tree_carry) == (W'(op_a) * W'(op_b)));

  // R1
  final_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_sum == tree_sum + tree_carry);

  // R1
  product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> prod == $past(W'(op_a) * W'(op_b)));

  // R2
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  // R2
  vld_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(prod));

endmodule

// File: tb/test_cmp42_mult.sv
module test_cmp42_mult;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        v8 = 1'b0, v16 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic        ov8, ov16;
  logic [15:0] p8;
  logic [31:0] p16;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  cmp42_mult i_cmp42_mult (.clk(clk), .rst_n(rst_n), .in_vld(v8), .op_a(a8), .op_b(b8),
                           .out_vld(ov8), .prod(p8));

  cmp42_mult #(.N(16)) i_cmp42_mult_w16 (.clk(clk), .rst_n(rst_n), .in_vld(v16),
                           .op_a(a16), .op_b(b16), .out_vld(ov16), .prod(p16));

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic string tag_for(input longint x, input longint y, input longint ones);
    if (x == 0 || y == 0) return "R6";
    if (x == ones && y == ones) return "R5";
    if ((x & (x - 1)) == 0 || (y & (y - 1)) == 0) return "R7";
    return "R1";
  endfunction

  task automatic run16(input logic [15:0] x, input logic [15:0] y);
    longint e;
    e = longint'(x) * longint'(y);
    @(negedge clk);
    a16 = x; b16 = y; v16 = 1'b1;
    @(negedge clk);
    v16 = 1'b0;
    chk(p16 == e[31:0], tag_for(x, y, 16'hffff), p16, e);
    chk(ov16 == 1'b1, "R2", ov16, 1);
    // R3: operands change with the strobe low; the product must not move
    a16 = ~x; b16 = y ^ 16'h5a5a;
    @(negedge clk);
    chk(p16 == e[31:0], "R3", p16, e);
    chk(ov16 == 1'b0, "R2", ov16, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R8 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp8;
    string       t8;
    // R4: cleared state while reset is held, even with inputs toggling
    @(negedge clk);
    a8 = 8'hff; b8 = 8'hff; a16 = 16'hffff; b16 = 16'h1234;
    @(negedge clk);
    chk(ov8 == 1'b0, "R4", ov8, 0);
    chk(p8 == 16'h0, "R4", p8, 0);
    chk(ov16 == 1'b0, "R4", ov16, 0);
    chk(p16 == 32'h0, "R4", p16, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ov8 == 1'b0, "R2", ov8, 0);
    chk(p8 == 16'h0, "R3", p8, 0);

    // R8: exhaustive N=8 sweep, one strobe per cycle
    exp8 = '0;
    t8   = "R1";
    for (int k = 0; k < 65536; k++) begin
      if (k > 0) begin
        chk(p8 == exp8, t8, p8, exp8);
        chk(ov8 == 1'b1, "R8", ov8, 1);
      end
      a8 = k[15:8]; b8 = k[7:0]; v8 = 1'b1;
      exp8 = 16'(a8) * 16'(b8);
      t8   = tag_for(a8, b8, 8'hff);
      @(negedge clk);
    end
    chk(p8 == exp8, t8, p8, exp8);
    chk(ov8 == 1'b1, "R8", ov8, 1);
    v8 = 1'b0; a8 = 8'h3c; b8 = 8'hc3;
    @(negedge clk);
    chk(ov8 == 1'b0, "R2", ov8, 0);
    chk(p8 == exp8, "R3", p8, exp8);

    // N=16 directed corners
    run16(16'h0000, 16'hbeef);
    run16(16'hffff, 16'h0000);
    run16(16'hffff, 16'hffff);
    for (int s = 0; s < 16; s++) begin
      run16(16'h1 << s, 16'hd6b3);
      run16(16'hffff, 16'h1 << s);
    end
    // N=16 random pairs
    for (int r = 0; r < 2000; r++) begin
      run16(16'($urandom), 16'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule